// File: doc/BRIEF.md
# Register Permutation Remap Table

This block holds a logical-to-physical index map for a 32-entry register file. It lets a processor carry out a register shuffle in one clock without moving any data: a permutation instruction only rewrites which physical entry each architectural register name selects. After the instruction, each listed register's former value can be read under the name of the next register in the cycle.

Two instruction variants are supported. The ring variant applies one rotation over up to five names. The split variant applies a two-element exchange and, independently, a rotation of up to three elements. Shorter cycles are written by repeating the last meaningful specifier in the unused trailing fields. A separate select input picks the variant, because the fixed bits of the word are the same for both.

The datapath reaches the register file through three translated address ports: two read ports and one write port. Each port maps an architectural name to its current physical index combinationally.

Top module: `regperm_map`

## Requirements
- R1: After reset, every architectural name i translates to physical index i.
- R2: A word is accepted only when bits 31:28 equal 4'b0001 and bits 24:22 equal 3'b000. Specifier a is {bits 27:25, bits 21:20}, b is bits 19:15, c is bits 14:10, d is bits 9:5 and e is bits 4:0. A word whose fixed bits differ changes no mapping.
- R3: With ring selected (sel_split = 0), an accepted word with distinct a, b, c, d, e rotates the map. Afterwards name b gives the index a had, c gives b's, d gives c's, e gives d's and a gives e's.
- R4: In ring mode, a cycle of length n < 5 is written by repeating the n-th specifier in all later fields. It then rotates only those n names, so two names act as a swap. Names outside the cycle keep their mapping.
- R5: With split selected (sel_split = 1), names a and b exchange their indices, and c, d, e rotate c to d to e to c, with both cycles applied in the same update.
- R6: A step whose source equals its destination leaves the map unchanged. A word whose specifiers all name one register, or a split word with a equal to b, alters nothing in the degenerate cycle.
- R7: The whole permutation takes effect at the single clock edge where the word is presented with perm_valid high. All new entries derive from the map as it was before that edge, and back-to-back words compose.
- R8: While perm_valid is low, the map does not change, whatever the word input holds.
- R9: rd_a_phys, rd_b_phys and wr_phys equal the current map entry of rd_a_arch, rd_b_arch and wr_arch in the same cycle, with no register in between.
- R10: The map is a permutation of 0..31 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| perm_valid | input | 1 | Permutation word present this cycle |
| sel_split | input | 1 | 0: ring of up to five, 1: pair plus triple |
| perm_word | input | 32 | Permutation instruction word |
| rd_a_arch | input | 5 | Read port A architectural name |
| rd_a_phys | output | 5 | Read port A physical index |
| rd_b_arch | input | 5 | Read port B architectural name |
| rd_b_phys | output | 5 | Read port B physical index |
| wr_arch | input | 5 | Write port architectural name |
| wr_phys | output | 5 | Write port physical index |

## Verification
Random ring words of every length from one to five are applied on top of an already scrambled map. Because the map is not the identity, a rotation in the wrong direction, or an entry taken from an updated entry instead of the old one, gives a different map. Split words mix swaps, degenerate pairs and rotations of two or three elements, which shows whether the two cycles are kept independent. Directed words cover a malformed opcode, a deasserted valid, an all-same ring, back-to-back updates and a read taken before the update edge, so that ignored input and same-cycle timing can be told apart from real updates.

// File: rtl/regperm_pkg.sv
package regperm_pkg;
  localparam int SPEC_W = 5;
  localparam int NSTEP  = 5;
  localparam int WORD_W = 32;

  typedef enum logic {KIND_RING = 1'b0, KIND_SPLIT = 1'b1} perm_kind_e;

  typedef struct packed {
    logic [SPEC_W-1:0] a;
    logic [SPEC_W-1:0] b;
    logic [SPEC_W-1:0] c;
    logic [SPEC_W-1:0] d;
    logic [SPEC_W-1:0] e;
  } spec_set_t;

  typedef struct packed {
    logic              en;
    logic [SPEC_W-1:0] dst;
    logic [SPEC_W-1:0] src;
  } step_t;

  function automatic logic word_shape_ok(input logic [WORD_W-1:0] w);
    return (w[31:28] == 4'b0001) && (w[24:22] == 3'b000);
  endfunction

  function automatic spec_set_t word_fields(input logic [WORD_W-1:0] w);
    spec_set_t s;
    s.a = {w[27:25], w[21:20]};
    s.b = w[19:15];
    s.c = w[14:10];
    s.d = w[9:5];
    s.e = w[4:0];
    return s;
  endfunction

  function automatic step_t make_step(input logic [SPEC_W-1:0] dst,
                                      input logic [SPEC_W-1:0] src);
    step_t t;
    t.dst = dst;
    t.src = src;
    t.en  = (dst != src);
    return t;
  endfunction
endpackage

// File: rtl/regperm_decode.sv
module regperm_decode
  import regperm_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  input  logic              valid_i,
  output spec_set_t         spec_o,
  output logic              shape_ok_o,
  output logic              fire_o
);
  always_comb begin
    spec_o     = word_fields(word_i);
    shape_ok_o = word_shape_ok(word_i);
    fire_o     = valid_i && shape_ok_o;
  end
endmodule

// File: rtl/regperm_steps.sv
module regperm_steps
  import regperm_pkg::*;
(
  input  spec_set_t              spec_i,
  input  perm_kind_e             kind_i,
  output step_t [NSTEP-1:0]      steps_o
);
  logic [SPEC_W-1:0] ring_list [NSTEP];
  step_t [NSTEP-1:0] ring_steps;
  step_t [NSTEP-1:0] split_steps;

  always_comb begin
    ring_list[0] = spec_i.a;
    ring_list[1] = spec_i.b;
    ring_list[2] = spec_i.c;
    ring_list[3] = spec_i.d;
    ring_list[4] = spec_i.e;
  end

  // ring: the value under list[k] moves to list[k+1], wrapping
  for (genvar k = 0; k < NSTEP; k++) begin : g_ring
    assign ring_steps[k] = make_step(ring_list[(k + 1) % NSTEP], ring_list[k]);
  end

  // split: exchange of a and b, rotation c -> d -> e -> c
  assign split_steps[0] = make_step(spec_i.b, spec_i.a);
  assign split_steps[1] = make_step(spec_i.a, spec_i.b);
  assign split_steps[2] = make_step(spec_i.d, spec_i.c);
  assign split_steps[3] = make_step(spec_i.e, spec_i.d);
  assign split_steps[4] = make_step(spec_i.c, spec_i.e);

  assign steps_o = (kind_i == KIND_SPLIT) ? split_steps : ring_steps;
endmodule

// File: rtl/regperm_table.sv
module regperm_table
  import regperm_pkg::*;
#(
  parameter int NREG  = 32,
  localparam int IDX_W = $clog2(NREG)
)(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   apply_i,
  input  step_t [NSTEP-1:0]      steps_i,
  output logic [NREG*IDX_W-1:0]  map_flat_o
);
  logic [IDX_W-1:0] cur [NREG];
  logic [IDX_W-1:0] nxt [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_entry
    // every source is read from cur, the map before this edge
    always_comb begin
      nxt[i] = cur[i];
      for (int k = NSTEP - 1; k >= 0; k--) begin
        if (apply_i && steps_i[k].en && (steps_i[k].dst == IDX_W'(i)))
          nxt[i] = cur[steps_i[k].src];
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) cur[i] <= IDX_W'(i);
      else        cur[i] <= nxt[i];
    end

    assign map_flat_o[i*IDX_W +: IDX_W] = cur[i];
  end
endmodule

// File: rtl/regperm_xlate.sv
module regperm_xlate #(
  parameter int NREG  = 32,
  localparam int IDX_W = $clog2(NREG)
)(
  input  logic [NREG*IDX_W-1:0] map_flat_i,
  input  logic [IDX_W-1:0]      arch_i,
  output logic [IDX_W-1:0]      phys_o
);
  assign phys_o = map_flat_i[arch_i*IDX_W +: IDX_W];
endmodule

// File: rtl/regperm_map.sv
module regperm_map
  import regperm_pkg::*;
#(
  parameter int NREG  = 32,
  localparam int IDX_W = $clog2(NREG),
  localparam int NPORT = 3
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              perm_valid,
  input  logic              sel_split,
  input  logic [WORD_W-1:0] perm_word,
  input  logic [IDX_W-1:0]  rd_a_arch,
  output logic [IDX_W-1:0]  rd_a_phys,
  input  logic [IDX_W-1:0]  rd_b_arch,
  output logic [IDX_W-1:0]  rd_b_phys,
  input  logic [IDX_W-1:0]  wr_arch,
  output logic [IDX_W-1:0]  wr_phys
);
  spec_set_t             spec;
  logic                  shape_ok;
  logic                  apply_fire;
  perm_kind_e            kind;
  step_t [NSTEP-1:0]     steps;
  logic [NREG*IDX_W-1:0] map_flat;
  logic [IDX_W-1:0]      port_arch [NPORT];
  logic [IDX_W-1:0]      port_phys [NPORT];

  assign kind = sel_split ? KIND_SPLIT : KIND_RING;

  regperm_decode u_dec (
    .word_i     (perm_word),
    .valid_i    (perm_valid),
    .spec_o     (spec),
    .shape_ok_o (shape_ok),
    .fire_o     (apply_fire)
  );

  regperm_steps u_steps (
    .spec_i  (spec),
    .kind_i  (kind),
    .steps_o (steps)
  );

  regperm_table #(.NREG(NREG)) u_tab (
    .clk        (clk),
    .rst_n      (rst_n),
    .apply_i    (apply_fire),
    .steps_i    (steps),
    .map_flat_o (map_flat)
  );

  assign port_arch[0] = rd_a_arch;
  assign port_arch[1] = rd_b_arch;
  assign port_arch[2] = wr_arch;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    regperm_xlate #(.NREG(NREG)) u_xl (
      .map_flat_i (map_flat),
      .arch_i     (port_arch[p]),
      .phys_o     (port_phys[p])
    );
  end

  assign rd_a_phys = port_phys[0];
  assign rd_b_phys = port_phys[1];
  assign wr_phys   = port_phys[2];
endmodule

// File: rtl/regperm_map_chk.sv
module regperm_map_chk
  import regperm_pkg::*;
#(
  parameter int NREG  = 32,
  localparam int IDX_W = $clog2(NREG)
)(
  input logic                  clk,
  input logic                  rst_n,
  input logic                  perm_valid,
  input logic                  shape_ok,
  input logic                  apply_fire,
  input step_t [NSTEP-1:0]     steps,
  input logic [NREG*IDX_W-1:0] map_flat,
  input logic [IDX_W-1:0]      rd_a_arch,
  input logic [IDX_W-1:0]      rd_a_phys
);
  function automatic logic [IDX_W-1:0] ent(input logic [NREG*IDX_W-1:0] m,
                                           input logic [IDX_W-1:0] i);
    return m[i*IDX_W +: IDX_W];
  endfunction

  logic [NREG-1:0] seen;
  always_comb begin
    seen = '0;
    for (int i = 0; i < NREG; i++) seen[map_flat[i*IDX_W +: IDX_W]] = 1'b1;
  end

  a_r10_is_permutation: assert property (@(posedge clk) disable iff (!rst_n)
    seen == {NREG{1'b1}});

  a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !perm_valid |=> $stable(map_flat));

  a_r2_bad_shape_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (perm_valid && !shape_ok) |=> $stable(map_flat));

  a_r7_first_step_old_source: assert property (@(posedge clk) disable iff (!rst_n)
    (apply_fire && steps[0].en) |=>
      ent(map_flat, $past(steps[0].dst)) == $past(ent(map_flat, steps[0].src)));

  a_r9_read_port_a: assert property (@(posedge clk) disable iff (!rst_n)
    rd_a_phys == ent(map_flat, rd_a_arch));
endmodule

bind regperm_map regperm_map_chk #(.NREG(NREG)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .perm_valid (perm_valid),
  .shape_ok   (shape_ok),
  .apply_fire (apply_fire),
  .steps      (steps),
  .map_flat   (map_flat),
  .rd_a_arch  (rd_a_arch),
  .rd_a_phys  (rd_a_phys)
);

// File: tb/regperm_map_tb_top.sv
`timescale 1ns/1ps
module regperm_map_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        perm_valid;
  logic        sel_split;
  logic [31:0] perm_word;
  logic [4:0]  rd_a_arch, rd_b_arch, wr_arch;
  logic [4:0]  rd_a_phys, rd_b_phys, wr_phys;

  int n_vec  = 0;
  int n_bad  = 0;
  bit closed = 0;

  logic [4:0] mdl [32];

  always #10 clk = ~clk;

  regperm_map dut_i (
    .clk(clk), .rst_n(rst_n), .perm_valid(perm_valid), .sel_split(sel_split),
    .perm_word(perm_word), .rd_a_arch(rd_a_arch), .rd_a_phys(rd_a_phys),
    .rd_b_arch(rd_b_arch), .rd_b_phys(rd_b_phys), .wr_arch(wr_arch),
    .wr_phys(wr_phys)
  );

  function automatic logic [31:0] mk_word(input logic [4:0] a, b, c, d, e);
    return {4'b0001, a[4:2], 3'b000, a[1:0], b, c, d, e};
  endfunction

  // the value under names[k] shows up under names[(k+1) mod n]
  function automatic void rotate(input logic [4:0] names [5], input int n);
    logic [4:0] old [32];
    for (int i = 0; i < 32; i++) old[i] = mdl[i];
    for (int k = 0; k < n; k++) mdl[names[(k + 1) % n]] = old[names[k]];
  endfunction

  task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic sweep(input string req);
    for (int i = 0; i < 32; i++) begin
      rd_a_arch = 5'(i); rd_b_arch = 5'(31 - i); wr_arch = 5'(i);
      #0.25;
      check(req, rd_a_phys, mdl[i]);
      check(req, rd_b_phys, mdl[31 - i]);
      check({req, " R9 write port"}, wr_phys, mdl[i]);
    end
  endtask

  task automatic issue(input logic [31:0] w, input logic split);
    @(negedge clk);
    perm_valid = 1'b1; perm_word = w; sel_split = split;
    @(negedge clk);
    perm_valid = 1'b0; perm_word = $urandom;
  endtask

  task automatic pick(output logic [4:0] p [5]);
    logic [4:0] pool [32];
    for (int i = 0; i < 32; i++) pool[i] = 5'(i);
    for (int i = 0; i < 5; i++) begin
      int j = i + int'($urandom_range(31 - i));
      logic [4:0] t = pool[i];
      pool[i] = pool[j]; pool[j] = t;
      p[i] = pool[i];
    end
  endtask

  task automatic ring_case(input int n, input string req);
    logic [4:0] p [5];
    pick(p);
    for (int k = n; k < 5; k++) p[k] = p[n - 1];
    issue(mk_word(p[0], p[1], p[2], p[3], p[4]), 1'b0);
    rotate(p, n);
    sweep(req);
  endtask

  task automatic split_case(input int n1, input int n2, input string req);
    logic [4:0] p [5];
    logic [4:0] pair [5];
    logic [4:0] tri3 [5];
    pick(p);
    if (n1 == 1) p[1] = p[0];
    if (n2 == 1) begin p[3] = p[2]; p[4] = p[2]; end
    if (n2 == 2) p[4] = p[3];
    issue(mk_word(p[0], p[1], p[2], p[3], p[4]), 1'b1);
    pair[0] = p[0]; pair[1] = p[1];
    tri3[0] = p[2]; tri3[1] = p[3]; tri3[2] = p[4];
    for (int k = 2; k < 5; k++) pair[k] = p[1];
    for (int k = 3; k < 5; k++) tri3[k] = p[4];
    rotate(pair, n1);
    rotate(tri3, n2);
    sweep(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!closed) begin
      closed = 1;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [4:0] p [5];
    void'($urandom(32'd2718));
    rst_n = 1'b0; perm_valid = 1'b0; sel_split = 1'b0; perm_word = '0;
    rd_a_arch = '0; rd_b_arch = '0; wr_arch = '0;
    for (int i = 0; i < 32; i++) mdl[i] = 5'(i);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    sweep("R1 reset identity");

    // directed: five-element ring with fixed names
    issue(mk_word(5'd1, 5'd2, 5'd3, 5'd4, 5'd5), 1'b0);
    p = '{5'd1, 5'd2, 5'd3, 5'd4, 5'd5}; rotate(p, 5);
    sweep("R3 five ring");

    // directed: swap via trailing repeats
    issue(mk_word(5'd30, 5'd7, 5'd7, 5'd7, 5'd7), 1'b0);
    p = '{5'd30, 5'd7, 5'd7, 5'd7, 5'd7}; rotate(p, 2);
    sweep("R4 ring swap");

    // all-same ring word: no change
    issue(mk_word(5'd9, 5'd9, 5'd9, 5'd9, 5'd9), 1'b0);
    sweep("R6 all-same ring");

    // malformed shape: top nibble wrong, then middle bits wrong
    issue(mk_word(5'd1, 5'd2, 5'd3, 5'd4, 5'd5) ^ 32'h8000_0000, 1'b0);
    sweep("R2 bad top bits");
    issue(mk_word(5'd1, 5'd2, 5'd3, 5'd4, 5'd5) | 32'h0040_0000, 1'b1);
    sweep("R2 bad middle bits");

    // valid low with a well-formed word
    @(negedge clk);
    perm_valid = 1'b0; sel_split = 1'b0; perm_word = mk_word(5'd3, 5'd8, 5'd11, 5'd0, 5'd31);
    repeat (2) @(negedge clk);
    sweep("R8 valid low");

    // split with a==b and a full triple
    issue(mk_word(5'd6, 5'd6, 5'd12, 5'd13, 5'd14), 1'b1);
    p = '{5'd12, 5'd13, 5'd14, 5'd14, 5'd14}; rotate(p, 3);
    sweep("R6 split degenerate pair");

    // R7: before the edge the old map is still visible; then back-to-back
    @(negedge clk);
    perm_valid = 1'b1; sel_split = 1'b0;
    perm_word = mk_word(5'd20, 5'd21, 5'd21, 5'd21, 5'd21);
    rd_a_arch = 5'd21; #1;
    check("R7 no early change", rd_a_phys, mdl[21]);
    @(negedge clk);
    perm_word = mk_word(5'd21, 5'd22, 5'd22, 5'd22, 5'd22);
    @(negedge clk);
    perm_valid = 1'b0;
    p = '{5'd20, 5'd21, 5'd21, 5'd21, 5'd21}; rotate(p, 2);
    p = '{5'd21, 5'd22, 5'd22, 5'd22, 5'd22}; rotate(p, 2);
    sweep("R7 back-to-back");

    // random mix
    for (int it = 0; it < 200; it++) begin
      if ($urandom_range(1) == 0) begin
        int n = int'($urandom_range(1, 5));
        ring_case(n, (n == 5) ? "R3 random ring" : "R4 random short ring");
      end else begin
        split_case(int'($urandom_range(1, 2)), int'($urandom_range(1, 3)), "R5 random split");
      end
    end

    // one more directed split after a scrambled map
    split_case(2, 3, "R5 split pair and triple");
    ring_case(5, "R10 ring on scrambled map");

    if (!closed) begin
      closed = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule